// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It walks a two-level radix page table held in memory. A request carries the virtual address, an access type (read or write) and a privilege flag (user or supervisor). The walker then reads two words from a simple memory port, one at a time: first the directory entry, then the table entry. It returns either the physical address or a fault, together with the fault cause and the level at which the walk stopped. Software loads the directory base register through a separate write strobe.

Address split:
- Bits [31:22] index the directory.
- Bits [21:12] index the second-level table.
- Bits [11:0] are the byte offset within a 4 KB page.

Entry format (both levels):
- Bits [31:12] hold a 4 KB-aligned frame number.
- Bit 0 is the present flag.
- Bit 1 grants write access.
- Bit 2 grants user access.

A value of 0x7 in the low bits therefore gives full user read-write access. The walker accepts one request at a time. The request, memory-request and response channels each use a valid/ready handshake. The memory response is a single valid strobe, which the walker always accepts while it is waiting for one.

Top module: `pgw_walker`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0 and mem_req_valid is 0.
- R2: The first memory read of a walk is at address {base[31:12], va[31:22], 2'b00}. The low 12 bits of the base value written on base_we have no effect.
- R3: The second memory read of a walk is at address {dir_entry[31:12], va[21:12], 2'b00}.
- R4: A walk that passes both levels responds with rsp_fault=0, rsp_cause=0 and rsp_paddr={tbl_entry[31:12], va[11:0]}.
- R5: An entry whose bit 0 is 0 ends the walk with rsp_fault=1 and rsp_cause=1. rsp_level is 0 for the directory level and 1 for the table level. A directory-level fault issues no second memory read.
- R6: A write (req_write=1) that meets an entry whose bit 1 is 0, at either level, ends the walk with rsp_cause=2 and the level of that entry. A read ignores bit 1.
- R7: A user access (req_user=1) that meets an entry whose bit 2 is 0, at either level, ends the walk with rsp_cause=2 and the level of that entry. A supervisor access ignores bit 2.
- R8: At one entry, a clear present bit takes priority over a protection failure. The directory level is judged before the table level.
- R9: mem_req_valid stays high with a stable address until mem_req_ready. No second memory request is raised while a read is outstanding. req_ready stays low from acceptance until the response is taken, and rsp_valid holds with stable fields until rsp_ready.
- R10: rsp_vaddr returns the virtual address of the accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_we | input | 1 | Load strobe for the directory base register |
| base_wdata | input | 32 | New directory base (low 12 bits ignored) |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_user | input | 1 | 1 = user-mode access, 0 = supervisor |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Entry word read from memory |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_paddr | output | 32 | Physical address (0 on a fault) |
| rsp_fault | output | 1 | 1 when the walk faulted |
| rsp_cause | output | 2 | 0 none, 1 not present, 2 protection |
| rsp_level | output | 1 | Level where a fault stopped the walk: 0 directory, 1 table |
| rsp_vaddr | output | 32 | Virtual address of the translated request |

## Verification
The hardest case to reach is a fault at the table level that only the second entry's permissions cause. To reach it, the first entry must pass all three checks for the given access type while the second entry fails exactly one of them, and the priority between absence and protection must still be visible. The bench reaches it by sweeping every combination of the three permission bits at both levels against all four pairs of access type and privilege. Memory ready stalls and response latencies vary with the sweep index, so that the hold and single-outstanding rules are also exercised under backpressure.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

   typedef enum logic [1:0] {
      CAUSE_NONE   = 2'd0,
      CAUSE_ABSENT = 2'd1,
      CAUSE_PROT   = 2'd2
   } pgw_cause_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DIR_REQ,
      ST_DIR_WAIT,
      ST_TBL_REQ,
      ST_TBL_WAIT,
      ST_DONE
   } pgw_state_e;

   localparam int PERM_BITS = 3;
   localparam int PERM_PRESENT = 0;
   localparam int PERM_WRITE = 1;
   localparam int PERM_USER = 2;

endpackage

// File: rtl/pgw_entry_check.sv
module pgw_entry_check
   import pgw_pkg::*;
(
   input  logic [PERM_BITS-1:0] perm,
   input  logic                 is_write,
   input  logic                 is_user,
   output logic [1:0]           cause
);

   logic write_denied;
   logic user_denied;

   assign write_denied = is_write && !perm[PERM_WRITE];
   assign user_denied  = is_user && !perm[PERM_USER];

   always_comb begin
      if (!perm[PERM_PRESENT])
         cause = CAUSE_ABSENT;
      else if (write_denied || user_denied)
         cause = CAUSE_PROT;
      else
         cause = CAUSE_NONE;
   end

   // R6 / R7: a protection fault can only come from a write or a user access
   always_comb begin
      if (cause == CAUSE_PROT)
         assert_prot_needs_access_R6 : assert (is_write || is_user);
   end

endmodule

// File: rtl/pgw_addr_join.sv
module pgw_addr_join #(
   parameter int FRAME_W = 20,
   parameter int IDX_W   = 10,
   parameter int SUB_W   = 2
) (
   input  logic [FRAME_W-1:0]             frame,
   input  logic [IDX_W-1:0]               index,
   output logic [FRAME_W+IDX_W+SUB_W-1:0] addr
);

   generate
      if (SUB_W == 0) begin : g_byte
         assign addr = {frame, index};
      end else begin : g_word
         assign addr = {frame, index, {SUB_W{1'b0}}};
      end
   endgenerate

endmodule

// File: rtl/pgw_walker.sv
module pgw_walker
   import pgw_pkg::*;
#(
   parameter int VA_W        = 32,
   parameter int L1_W        = 10,
   parameter int L2_W        = 10,
   parameter int ENTRY_BYTES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              base_we,
   input  logic [31:0]       base_wdata,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [VA_W-1:0]   req_vaddr,
   input  logic              req_write,
   input  logic              req_user,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [31:0]       mem_req_addr,
   input  logic              mem_rsp_valid,
   input  logic [31:0]       mem_rsp_data,
   output logic              rsp_valid,
   input  logic              rsp_ready,
   output logic [31:0]       rsp_paddr,
   output logic              rsp_fault,
   output logic [1:0]        rsp_cause,
   output logic              rsp_level,
   output logic [VA_W-1:0]   rsp_vaddr
);

   localparam int OFF_W   = VA_W - L1_W - L2_W;
   localparam int SUB_W   = $clog2(ENTRY_BYTES);
   localparam int ENTRY_W = 8 * ENTRY_BYTES;
   localparam int FRAME_W = ENTRY_W - OFF_W;
   localparam int PA_W    = ENTRY_W;

   generate
      if (L1_W + SUB_W != OFF_W) begin : g_bad_l1
         $error("directory index plus entry size must fill the page offset");
      end
      if (L2_W + SUB_W != OFF_W) begin : g_bad_l2
         $error("table index plus entry size must fill the page offset");
      end
      if (PA_W != 32) begin : g_bad_pa
         $error("entry width must match the 32-bit address ports");
      end
   endgenerate

   pgw_state_e             state_q;
   logic [FRAME_W-1:0]     base_frame_q;
   logic [VA_W-1:0]        va_q;
   logic                   wr_q;
   logic                   usr_q;
   logic [PA_W-1:0]        addr_q;
   logic [PA_W-1:0]        paddr_q;
   logic [1:0]             cause_q;
   logic                   level_q;

   logic [PA_W-1:0]        dir_addr;
   logic [PA_W-1:0]        tbl_addr;
   logic [PA_W-1:0]        final_addr;
   logic [1:0]             chk_cause;
   logic [FRAME_W-1:0]     rsp_frame;
   logic                   req_fire;
   logic                   rsp_fire;
   logic                   mem_fire;
   logic                   entry_in;
   logic                   unused_bits;

   assign rsp_frame = mem_rsp_data[ENTRY_W-1:OFF_W];
   assign unused_bits = ^{base_wdata[OFF_W-1:0], mem_rsp_data[OFF_W-1:PERM_BITS]};

   pgw_addr_join #(.FRAME_W(FRAME_W), .IDX_W(L1_W), .SUB_W(SUB_W)) u_dir_join (
      .frame (base_frame_q),
      .index (req_vaddr[VA_W-1 -: L1_W]),
      .addr  (dir_addr)
   );

   pgw_addr_join #(.FRAME_W(FRAME_W), .IDX_W(L2_W), .SUB_W(SUB_W)) u_tbl_join (
      .frame (rsp_frame),
      .index (va_q[OFF_W+L2_W-1:OFF_W]),
      .addr  (tbl_addr)
   );

   pgw_addr_join #(.FRAME_W(FRAME_W), .IDX_W(OFF_W), .SUB_W(0)) u_pa_join (
      .frame (rsp_frame),
      .index (va_q[OFF_W-1:0]),
      .addr  (final_addr)
   );

   pgw_entry_check u_check (
      .perm     (mem_rsp_data[PERM_BITS-1:0]),
      .is_write (wr_q),
      .is_user  (usr_q),
      .cause    (chk_cause)
   );

   assign req_ready     = (state_q == ST_IDLE);
   assign mem_req_valid = (state_q == ST_DIR_REQ) || (state_q == ST_TBL_REQ);
   assign mem_req_addr  = addr_q;
   assign rsp_valid     = (state_q == ST_DONE);
   assign rsp_paddr     = paddr_q;
   assign rsp_fault     = (cause_q != CAUSE_NONE);
   assign rsp_cause     = cause_q;
   assign rsp_level     = level_q;
   assign rsp_vaddr     = va_q;

   assign req_fire = req_valid && req_ready;
   assign rsp_fire = rsp_valid && rsp_ready;
   assign mem_fire = mem_req_valid && mem_req_ready;
   assign entry_in = mem_rsp_valid &&
                     ((state_q == ST_DIR_WAIT) || (state_q == ST_TBL_WAIT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         base_frame_q <= '0;
      else if (base_we)
         base_frame_q <= base_wdata[PA_W-1:OFF_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         va_q    <= '0;
         wr_q    <= 1'b0;
         usr_q   <= 1'b0;
         addr_q  <= '0;
         paddr_q <= '0;
         cause_q <= CAUSE_NONE;
         level_q <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (req_fire) begin
                  va_q    <= req_vaddr;
                  wr_q    <= req_write;
                  usr_q   <= req_user;
                  addr_q  <= dir_addr;
                  state_q <= ST_DIR_REQ;
               end
            end
            ST_DIR_REQ: begin
               if (mem_fire)
                  state_q <= ST_DIR_WAIT;
            end
            ST_TBL_REQ: begin
               if (mem_fire)
                  state_q <= ST_TBL_WAIT;
            end
            ST_DIR_WAIT, ST_TBL_WAIT: begin
               if (entry_in) begin
                  if (chk_cause != CAUSE_NONE) begin
                     cause_q <= chk_cause;
                     level_q <= (state_q == ST_TBL_WAIT);
                     paddr_q <= '0;
                     state_q <= ST_DONE;
                  end else if (state_q == ST_DIR_WAIT) begin
                     addr_q  <= tbl_addr;
                     state_q <= ST_TBL_REQ;
                  end else begin
                     cause_q <= CAUSE_NONE;
                     level_q <= 1'b1;
                     paddr_q <= final_addr;
                     state_q <= ST_DONE;
                  end
               end
            end
            ST_DONE: begin
               if (rsp_fire)
                  state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R9: a memory request is held with a stable address until it is taken
   assert_memreq_hold_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

   // R9: a result is held with stable fields until it is taken
   assert_rsp_hold_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) &&
                                  $stable(rsp_cause) && $stable(rsp_level));

   // R9: an accepted memory request is not followed at once by another one
   assert_one_outstanding_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && mem_req_ready |=> !mem_req_valid);

   // R9: no new request is taken while a walk or a result is pending
   assert_busy_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      !(req_ready && (rsp_valid || mem_req_valid)));

   // R4: a successful translation keeps the page offset
   assert_offset_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_fault |-> rsp_paddr[OFF_W-1:0] == rsp_vaddr[OFF_W-1:0]);

   // R5: only defined cause codes appear on a result
   assert_cause_code_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> rsp_cause != 2'd3);

endmodule

// File: tb/sim_pgw_walker.sv
module sim_pgw_walker;

   localparam int CLK_PERIOD = 10;

   logic        clk;
   logic        rst_n;
   logic        base_we;
   logic [31:0] base_wdata;
   logic        req_valid;
   logic        req_ready;
   logic [31:0] req_vaddr;
   logic        req_write;
   logic        req_user;
   logic        mem_req_valid;
   logic        mem_req_ready;
   logic [31:0] mem_req_addr;
   logic        mem_rsp_valid;
   logic [31:0] mem_rsp_data;
   logic        rsp_valid;
   logic        rsp_ready;
   logic [31:0] rsp_paddr;
   logic        rsp_fault;
   logic [1:0]  rsp_cause;
   logic        rsp_level;
   logic [31:0] rsp_vaddr;

   int n_tests;
   int n_fail;

   pgw_walker u0 (
      .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_wdata(base_wdata),
      .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
      .req_write(req_write), .req_user(req_user),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
      .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause),
      .rsp_level(rsp_level), .rsp_vaddr(rsp_vaddr)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic walk(input int idx, input logic [31:0] va, input bit wr,
                       input bit usr, input logic [31:0] base,
                       input logic [31:0] dir_e, input logic [31:0] tbl_e,
                       input int stall, input int lat);
      int          nreads;
      int          cyc;
      logic [31:0] seen;
      logic [31:0] exp_addr;
      logic [1:0]  exp_cause;
      bit          exp_lvl;
      int          exp_reads;
      // expected result from the requirements
      exp_cause = 2'd0;
      exp_lvl   = 1'b0;
      exp_reads = 2;
      if (!dir_e[0]) begin
         exp_cause = 2'd1; exp_lvl = 1'b0; exp_reads = 1;
      end else if ((wr && !dir_e[1]) || (usr && !dir_e[2])) begin
         exp_cause = 2'd2; exp_lvl = 1'b0; exp_reads = 1;
      end else if (!tbl_e[0]) begin
         exp_cause = 2'd1; exp_lvl = 1'b1;
      end else if ((wr && !tbl_e[1]) || (usr && !tbl_e[2])) begin
         exp_cause = 2'd2; exp_lvl = 1'b1;
      end

      @(negedge clk);
      base_we = 1'b1;
      base_wdata = base;
      @(negedge clk);
      base_we = 1'b0;
      req_valid = 1'b1;
      req_vaddr = va;
      req_write = wr;
      req_user = usr;
      @(negedge clk);
      req_valid = 1'b0;
      check(!req_ready, "R9 busy after accept", {31'd0, req_ready}, 32'd0);

      nreads = 0;
      cyc = 0;
      while (!rsp_valid && cyc < 200) begin
         if (mem_req_valid) begin
            seen = mem_req_addr;
            for (int s = 0; s < stall; s++) begin
               @(negedge clk);
               check(mem_req_valid && mem_req_addr == seen, "R9 request hold",
                     mem_req_addr, seen);
            end
            mem_req_ready = 1'b1;
            @(negedge clk);
            mem_req_ready = 1'b0;
            nreads++;
            if (nreads == 1)
               exp_addr = {base[31:12], va[31:22], 2'b00};
            else
               exp_addr = {dir_e[31:12], va[21:12], 2'b00};
            check(seen == exp_addr, (nreads == 1) ? "R2 directory read address" :
                  "R3 table read address", seen, exp_addr);
            check(!mem_req_valid, "R9 one outstanding", {31'd0, mem_req_valid}, 32'd0);
            for (int l = 0; l < lat; l++) begin
               @(negedge clk);
               check(!mem_req_valid, "R9 no request while waiting",
                     {31'd0, mem_req_valid}, 32'd0);
            end
            mem_rsp_valid = 1'b1;
            mem_rsp_data = (nreads == 1) ? dir_e : tbl_e;
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            mem_rsp_data = 32'hdead_beef;
         end else begin
            @(negedge clk);
         end
         cyc++;
      end

      check(rsp_valid, "R9 response arrives", {31'd0, rsp_valid}, 32'd1);
      check(nreads == exp_reads, (exp_lvl == 1'b0 && exp_cause != 0) ?
            "R5 read count on directory fault" : "R3 read count", nreads, exp_reads);
      check(rsp_cause == exp_cause, (exp_cause == 2'd1) ? "R5 absent cause R8" :
            (exp_cause == 2'd2) ? (wr ? "R6 protection cause" : "R7 protection cause") :
            "R4 no fault cause", {30'd0, rsp_cause}, {30'd0, exp_cause});
      check(rsp_fault == (exp_cause != 0), "R4 fault flag",
            {31'd0, rsp_fault}, {31'd0, exp_cause != 0});
      if (exp_cause != 0)
         check(rsp_level == exp_lvl, "R5 fault level R8",
               {31'd0, rsp_level}, {31'd0, exp_lvl});
      else
         check(rsp_paddr == {tbl_e[31:12], va[11:0]}, "R4 physical address",
               rsp_paddr, {tbl_e[31:12], va[11:0]});
      check(rsp_vaddr == va, "R10 echoed address", rsp_vaddr, va);
      check(!req_ready, "R9 no accept while result pending",
            {31'd0, req_ready}, 32'd0);
      if (idx % 4 == 0) begin
         @(negedge clk);
         check(rsp_valid, "R9 result held", {31'd0, rsp_valid}, 32'd1);
      end
      rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0;
      check(req_ready && !rsp_valid, "R9 idle after take",
            {30'd0, req_ready, rsp_valid}, 32'd2);
   endtask

   initial begin
      n_tests = 0;
      n_fail = 0;
      rst_n = 1'b0;
      base_we = 1'b0;
      base_wdata = '0;
      req_valid = 1'b0;
      req_vaddr = '0;
      req_write = 1'b0;
      req_user = 1'b0;
      mem_req_ready = 1'b0;
      mem_rsp_valid = 1'b0;
      mem_rsp_data = '0;
      rsp_ready = 1'b0;
      repeat (3) @(negedge clk);
      check(req_ready && !rsp_valid && !mem_req_valid, "R1 reset state",
            {29'd0, req_ready, rsp_valid, mem_req_valid}, 32'd4);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready && !rsp_valid && !mem_req_valid, "R1 idle after reset",
            {29'd0, req_ready, rsp_valid, mem_req_valid}, 32'd4);

      for (int i = 0; i < 256; i++) begin
         logic [31:0] va;
         logic [31:0] base;
         logic [31:0] dir_e;
         logic [31:0] tbl_e;
         int dp = i % 8;
         int tp = (i / 8) % 8;
         int mode = i / 64;
         va = {10'((i * 37) % 1024), 10'((i * 91 + 5) % 1024), 12'((i * 13 + 7) % 4096)};
         base = {20'((i * 4951 + 256) % 1048576), 12'((i * 2749) % 4096)};
         dir_e = {20'((i * 4919 + 4096) % 1048576), 9'((i * 3) % 512), 3'(dp)};
         tbl_e = {20'((i * 7013 + 777) % 1048576), 9'((i * 5) % 512), 3'(tp)};
         walk(i, va, mode[0], mode[1], base, dir_e, tbl_e, i % 3, i % 2);
      end

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired R9 actual=%h expected=%h", 32'd0, 32'd1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule